// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receive half of an inter-processor mailbox. Other cores hand in messages on a push port. Each message is a 64-bit payload tagged with a 3-bit source channel. The messages are held in a circular queue of `DEPTH` entries. A local processor drains the queue through a small register window. It reads the oldest message as a low word, a high word and a channel number, then writes a trigger register to discard that entry and advance the read pointer.

The status word exposes the raw read and write pointers together with a full flag. Software can therefore work out the occupancy itself: the flag resolves the case where the two pointers are equal. A pending bit records that the queue holds data, and a mask bit gates it onto the interrupt line. A depth register lets software learn the queue size, and a reset register empties the queue.

Top module: `mbx_rx_queue`

## Requirements
- R1: After reset the status word reads 0 (both pointers 0, not full), the interrupt status reads 0, `irq` is low and `push_ready` is high.
- R2: The depth register at offset 0x24 reads `DEPTH-1`, which is 7 for the default depth of 8.
- R3: Entries leave in arrival order. Offset 0x4 returns the oldest payload bits 31:0, offset 0x8 returns its bits 63:32, and offset 0x0 returns its channel in bits 2:0.
- R4: A write with bit 0 set to the trigger register at 0xC removes the oldest entry and advances the read pointer. Such a write to an empty queue, or a trigger write with bit 0 clear, leaves the status word unchanged.
- R5: The status word at 0x14 holds the read pointer in bits 31:24, the write pointer in bits 23:16 and the full flag in bit 2. All other bits are 0. Equal pointers mean empty when the flag is 0 and full when it is 1.
- R6: With `DEPTH` entries held, `push_ready` is low and a push is refused, so the stored entries are unchanged.
- R7: Writing 0 to the reset register at 0x10 empties the queue, with both pointers and the flag returning to 0. A nonzero write there has no effect.
- R8: The pending bit (bit 0 of offset 0x18) becomes 1 one cycle after the queue is non-empty. `irq` equals the pending bit while mask bit 0 is 0, and is low while mask bit 0 is 1.
- R9: Writing 1 to bit 0 of offset 0x18 clears the pending bit. If entries remain, the bit sets again on the following cycle.
- R10: The mask register at 0x1C holds 5 bits, resets to 0x1F and reads back the last value written.
- R11: Reads of the head offsets (0x0, 0x4, 0x8) return 0 while the queue is empty.
- R12: Both pointers wrap from `DEPTH-1` to 0, so occupancy equals (write minus read) modulo `DEPTH` across wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | A sender offers a message |
| push_ready | output | 1 | The queue accepts the offered message this cycle |
| push_payload | input | 64 | Message payload |
| push_chan | input | 3 | Source channel of the message |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Not-empty interrupt |

## Verification
The assertions assume that a sender treats `push_ready` as the only acceptance signal. They also assume that register writes are single-cycle strobes decoded against the current queue state, so a trigger, a reset write and a push may land in the same cycle. The bench drives every input on the falling edge and raises one strobe at a time. It keeps a push offer to a single cycle and, in its random phase, only issues trigger writes after the head has been compared. Full-queue pushes are offered deliberately, so that refusal is exercised inside these limits.

// File: rtl/mbx_rx_pkg.sv
package mbx_rx_pkg;
    localparam int DATA_W = 64;
    localparam int CHAN_W = 3;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 6;
    localparam int MASK_W = 5;
    localparam int PFLD_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CHAN  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LO    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_HI    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_FLUSH = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_DEPTH = 6'h24;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] payload;
    } mbx_msg_t;

    typedef struct packed {
        logic               pop_req;
        logic               flush;
        logic               clr_req;
        logic               mask_we;
        logic [MASK_W-1:0]  mask_val;
    } mbx_ctl_t;

    function automatic logic [REG_W-1:0] pack_status(
        input logic [PFLD_W-1:0] rd,
        input logic [PFLD_W-1:0] wr,
        input logic              full);
        logic [REG_W-1:0] w;
        w        = '0;
        w[31:24] = rd;
        w[23:16] = wr;
        w[2]     = full;
        return w;
    endfunction
endpackage

// File: rtl/mbx_rx_store.sv
module mbx_rx_store
    import mbx_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_valid,
    input  mbx_msg_t                     push_msg,
    output logic                         push_ready,
    output logic                         push_fire,
    input  logic                         pop_req,
    input  logic                         flush,
    output mbx_msg_t                     head,
    output logic [$clog2(DEPTH)-1:0]     rd_ptr,
    output logic [$clog2(DEPTH)-1:0]     wr_ptr,
    output logic                         fifo_full,
    output logic                         fifo_empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    mbx_msg_t        slots [DEPTH];
    logic            pop_fire;
    logic [PTR_W-1:0] wr_nxt, rd_nxt;

    assign fifo_empty = (rd_ptr == wr_ptr) && !fifo_full;
    assign push_ready = !fifo_full && !flush;
    assign push_fire  = push_valid && push_ready;
    assign pop_fire   = pop_req && !fifo_empty && !flush;
    assign wr_nxt     = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    assign rd_nxt     = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    assign head       = fifo_empty ? '0 : slots[rd_ptr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_fire && (wr_ptr == PTR_W'(i))) begin
                slots[i] <= push_msg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr    <= '0;
            wr_ptr    <= '0;
            fifo_full <= 1'b0;
        end else begin
            if (push_fire) wr_ptr <= wr_nxt;
            if (pop_fire)  rd_ptr <= rd_nxt;
            if (push_fire && !pop_fire && (wr_nxt == rd_ptr)) begin
                fifo_full <= 1'b1;
            end else if (pop_fire && !push_fire) begin
                fifo_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mbx_rx_irq.sv
module mbx_rx_irq
    import mbx_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic              clr_req,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_val,
    output logic              irq_pend,
    output logic [MASK_W-1:0] irq_mask,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pend <= 1'b0;
            irq_mask <= '1;
        end else begin
            irq_pend <= clr_req ? 1'b0 : (irq_pend || !fifo_empty);
            if (mask_we) irq_mask <= mask_val;
        end
    end

    assign irq = irq_pend && !irq_mask[0];
endmodule

// File: rtl/mbx_rx_regs.sv
module mbx_rx_regs
    import mbx_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    input  mbx_msg_t                 head,
    input  logic [$clog2(DEPTH)-1:0] rd_ptr,
    input  logic [$clog2(DEPTH)-1:0] wr_ptr,
    input  logic                     fifo_full,
    input  logic                     irq_pend,
    input  logic [MASK_W-1:0]        irq_mask,
    output mbx_ctl_t                 ctl,
    output logic [REG_W-1:0]         reg_rdata
);
    always_comb begin
        ctl          = '0;
        ctl.pop_req  = reg_we && (reg_addr == OFS_TRIG) && reg_wdata[0];
        ctl.flush    = reg_we && (reg_addr == OFS_FLUSH) && (reg_wdata == '0);
        ctl.clr_req  = reg_we && (reg_addr == OFS_PEND) && reg_wdata[0];
        ctl.mask_we  = reg_we && (reg_addr == OFS_MASK);
        ctl.mask_val = reg_wdata[MASK_W-1:0];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CHAN:  reg_rdata = REG_W'(head.chan);
            OFS_LO:    reg_rdata = head.payload[31:0];
            OFS_HI:    reg_rdata = head.payload[63:32];
            OFS_STAT:  reg_rdata = pack_status(PFLD_W'(rd_ptr), PFLD_W'(wr_ptr), fifo_full);
            OFS_PEND:  reg_rdata = REG_W'(irq_pend);
            OFS_MASK:  reg_rdata = REG_W'(irq_mask);
            OFS_DEPTH: reg_rdata = REG_W'(DEPTH - 1);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_rx_queue.sv
module mbx_rx_queue
    import mbx_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [63:0]       push_payload,
    input  logic [2:0]        push_chan,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int PTR_W = $clog2(DEPTH);

    mbx_msg_t          push_msg, head;
    mbx_ctl_t          ctl;
    logic              push_fire, fifo_full, fifo_empty;
    logic              pop_req, flush, clr_req;
    logic              irq_pend;
    logic [MASK_W-1:0] irq_mask;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;

    assign push_msg = '{chan: push_chan, payload: push_payload};
    assign pop_req  = ctl.pop_req;
    assign flush    = ctl.flush;
    assign clr_req  = ctl.clr_req;

    mbx_rx_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_msg(push_msg),
        .push_ready(push_ready), .push_fire(push_fire), .pop_req(pop_req),
        .flush(flush), .head(head), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    mbx_rx_irq u_irq (
        .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .clr_req(clr_req),
        .mask_we(ctl.mask_we), .mask_val(ctl.mask_val), .irq_pend(irq_pend),
        .irq_mask(irq_mask), .irq(irq)
    );

    mbx_rx_regs #(.DEPTH(DEPTH)) u_regs (
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .head(head), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .fifo_full(fifo_full),
        .irq_pend(irq_pend), .irq_mask(irq_mask), .ctl(ctl), .reg_rdata(reg_rdata)
    );
endmodule

// File: rtl/mbx_rx_queue_chk.sv
module mbx_rx_queue_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             push_ready,
    input logic             push_fire,
    input logic             pop_req,
    input logic             flush,
    input logic             clr_req,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic             irq_pend,
    input logic [PTR_W-1:0] rd_ptr
);
    p_full_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !push_ready);

    p_idle_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && pop_req && !push_fire && !flush) |=> $stable(rd_ptr));

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
        flush |=> fifo_empty);

    p_pend_follows_r8: assert property (@(posedge clk) disable iff (rst)
        (!fifo_empty && !clr_req) |=> irq_pend);

    p_clear_pend_r9: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> !irq_pend);
endmodule

bind mbx_rx_queue mbx_rx_queue_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst(rst), .push_ready(push_ready), .push_fire(push_fire),
    .pop_req(pop_req), .flush(flush), .clr_req(clr_req), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .irq_pend(irq_pend), .rd_ptr(rd_ptr)
);

// File: tb/tb_mbx_rx_queue.sv
module tb_mbx_rx_queue;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic        push_ready;
    logic [63:0] push_payload = '0;
    logic [2:0]  push_chan = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] q_pay[$];
    logic [2:0]  q_ch[$];
    int m_rd = 0;
    int m_wr = 0;

    always #5 clk = ~clk;

    mbx_rx_queue #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_ready(push_ready),
        .push_payload(push_payload), .push_chan(push_chan), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] w = '0;
        w[31:24] = 8'(m_rd);
        w[23:16] = 8'(m_wr);
        w[2]     = (q_pay.size() == DEPTH);
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push(input logic [63:0] p, input logic [2:0] c, input string req);
        logic exp_rdy;
        @(negedge clk);
        push_valid = 1'b1; push_payload = p; push_chan = c;
        exp_rdy = (q_pay.size() < DEPTH);
        #1 check(req, push_ready, exp_rdy);
        @(posedge clk); #1;
        push_valid = 1'b0;
        if (exp_rdy) begin
            q_pay.push_back(p); q_ch.push_back(c);
            m_wr = (m_wr + 1) % DEPTH;
        end
    endtask

    task automatic check_head(input string req);
        logic [31:0] v;
        logic [63:0] ep = (q_pay.size() > 0) ? q_pay[0] : 64'h0;
        logic [2:0]  ec = (q_ch.size() > 0) ? q_ch[0] : 3'h0;
        rd(6'h04, v); check(req, v, ep[31:0]);
        rd(6'h08, v); check(req, v, ep[63:32]);
        rd(6'h00, v); check(req, v, {29'h0, ec});
    endtask

    task automatic pop(input string req);
        wr(6'h0C, 32'h1);
        if (q_pay.size() > 0) begin
            void'(q_pay.pop_front()); void'(q_ch.pop_front());
            m_rd = (m_rd + 1) % DEPTH;
        end
    endtask

    task automatic check_status(input string req);
        logic [31:0] v;
        rd(6'h14, v);
        check(req, v, exp_status());
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 / R10 reset state
        check_status("R1 status");
        rd(6'h18, v); check("R1 pend", v, 0);
        check("R1 irq", irq, 0);
        check("R1 ready", push_ready, 1);
        rd(6'h1C, v); check("R10 mask reset", v, 32'h1F);
        // R2
        rd(6'h24, v); check("R2 depth", v, DEPTH - 1);
        // R11 / R4 empty queue
        check_head("R11 empty head");
        pop("R4");
        check_status("R4 empty trigger ignored");

        // R10 / R8
        wr(6'h1C, 32'h1E);
        rd(6'h1C, v); check("R10 mask readback", v, 32'h1E);
        push(64'hCAFE_0001_1234_5678, 3'd5, "R3 push");
        check("R8 pend one cycle late", irq, 0);
        @(posedge clk); #1;
        check("R8 irq set", irq, 1);
        check_head("R3 head");
        // R9 clear then re-set
        wr(6'h18, 32'h1);
        rd(6'h18, v); check("R9 cleared", v, 0);
        @(posedge clk); #1;
        check("R9 re-set", irq, 1);
        // R8 masked
        wr(6'h1C, 32'h1F);
        check("R8 masked irq", irq, 0);
        rd(6'h18, v); check("R8 pend while masked", v, 1);
        // R4 trigger with bit0 clear ignored
        wr(6'h0C, 32'h2);
        check_status("R4 bit0 clear ignored");
        pop("R4");
        check_status("R4 pop");
        wr(6'h18, 32'h1);
        @(posedge clk); #1;
        rd(6'h18, v); check("R9 stays clear when empty", v, 0);

        // R6 / R5 fill
        for (int i = 0; i < DEPTH; i++) push({32'hA5A5_0000 + i, 32'h0F0F_0000 + i}, 3'(i), "R6 fill");
        push(64'hDEAD_BEEF_DEAD_BEEF, 3'd7, "R6 refused push");
        check("R6 ready low", push_ready, 0);
        check_status("R5 full status");
        for (int i = 0; i < DEPTH; i++) begin
            check_head("R3 order");
            pop("R6");
        end
        check_status("R5 empty after drain");

        // R7
        push(64'h1, 3'd1, "R7"); push(64'h2, 3'd2, "R7"); push(64'h3, 3'd3, "R7");
        wr(6'h10, 32'h1);
        check_status("R7 nonzero ignored");
        wr(6'h10, 32'h0);
        q_pay.delete(); q_ch.delete(); m_rd = 0; m_wr = 0;
        check_status("R7 flushed");
        check("R7 ready", push_ready, 1);

        // R12 random with wrap
        for (int it = 0; it < 600; it++) begin
            int op = $urandom % 4;
            if (op < 2) push({$urandom, $urandom}, 3'($urandom), "R12 push");
            else if (op == 2) begin check_head("R12 head"); pop("R12"); end
            check_status("R12 status");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule